// File: doc/BRIEF.md
# Paged Nonvolatile Memory Port Controller

This block gives a host access to a large byte-wide battery-backed SRAM through two I/O ports. It holds a page (sector) register and an offset counter, and it concatenates the two into the memory address. The function of each port depends on the direction of the access. On the page port, a write selects a new page and rewinds the offset to zero, and a read fetches the byte at the current location. On the transfer port, a write stores a byte at the current location, and a read advances the offset by one. Data accesses leave the offset where it is. Software therefore walks a page by alternating data accesses with advance reads.

Host accesses arrive on a valid/ready request stream. Every read on either port returns exactly one beat on a valid/ready response stream. The block accepts a new request only when it is idle and no response is waiting. Back-pressure on the response stream stalls the request stream. A response beat holds its data until the host takes it. The block drives the memory chip-enable, output-enable and write-enable strobes with fixed setup, pulse, hold and access phases, each set in whole clock cycles. A hardware write-protect input suppresses the write pulse. Two activity indicators are stretched so that they stay visible.

Top module: `nvram_page_ctrl`

## Requirements
- R1: A write request with `req_port`=0 loads the low `SECT_W` bits of `req_wdata` into the page register and sets the offset to 0 in the cycle it is accepted. It produces no memory strobe and no response.
- R2: A read request with `req_port`=0 holds `mem_ce_n` and `mem_oe_n` low for `ACC_CYC` cycles. It then returns the byte present on `mem_dq_in` in the last of those cycles as one response beat, and the offset is unchanged.
- R3: A write request with `req_port`=1 drives `mem_dq_out` with the byte and holds `mem_dq_oe` high and `mem_ce_n` low for `SETUP_CYC` cycles. It then holds `mem_we_n` low for `PULSE_CYC` cycles and keeps `mem_ce_n` low for `HOLD_CYC` more cycles with `mem_we_n` high. The offset is unchanged.
- R4: A read request with `req_port`=1 adds one to the offset and returns one response beat of value 00h. It produces no memory strobe.
- R5: Advancing from offset 2^`OFS_W`-1 gives offset 0 and leaves the page register unchanged.
- R6: `mem_addr` always equals {page register, offset}: the page is in the upper `SECT_W` bits and the offset is in the lower `OFS_W` bits.
- R7: If `wr_protect` is high in the cycle a port-1 write is accepted, `mem_we_n` stays high for that whole transaction, the other strobes keep their R3 timing, and the memory contents stay as they were.
- R8: `led_rd` is high in each cycle that follows a cycle with `mem_oe_n` low, until `LED_HOLD` cycles after the last such cycle. `led_wr` follows `mem_we_n` in the same way.
- R9: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high only when no memory phase is running and no response is pending. `rsp_valid` and `rsp_data` hold steady until `rsp_ready` is high.
- R10: After reset the page and offset are 0, all strobes are high, `mem_dq_oe`, `rsp_valid` and both indicators are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = host write, 0 = host read |
| req_port | input | 1 | 0 = page port, 1 = transfer port |
| req_wdata | input | DATA_W | Write byte or page number |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | DATA_W | Read byte, or 00h after an advance |
| wr_protect | input | 1 | Blocks write pulses when high |
| mem_addr | output | SECT_W+OFS_W | Memory address {page, offset} |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | DATA_W | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | DATA_W | Data from memory |
| led_rd | output | 1 | Read activity indicator |
| led_wr | output | 1 | Write activity indicator |

## Verification
The bench builds the block with a 3-bit page and a 4-bit offset. Sixteen advance reads therefore reach the offset wrap, and the whole 128-byte memory can be modelled and read back. The phase lengths are set to 2 cycles of setup, 3 of pulse, 1 of hold and 2 of access, so that off-by-one errors in each phase show up as different cycle counts. An indicator hold of 4 cycles lets successive accesses retrigger the stretch before it runs out. With these values, response back-pressure and random mixes of page, data, advance and protected-write requests all fit in a short run.

// File: rtl/nvpg_pkg.sv
package nvpg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_RACC,
    ST_RSP
  } nvpg_state_e;

  localparam logic PORT_PAGE = 1'b0;
  localparam logic PORT_XFER = 1'b1;
endpackage

// File: rtl/nvpg_regs.sv
module nvpg_regs #(
  parameter int SECT_W = 8,
  parameter int OFS_W  = 10,
  localparam int AW    = SECT_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_page,
  input  logic [SECT_W-1:0] page_in,
  input  logic              step,
  output logic [AW-1:0]     addr
);
  logic [SECT_W-1:0] page_q;
  logic [OFS_W-1:0]  ofs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      ofs_q  <= '0;
    end else if (ld_page) begin
      page_q <= page_in;
      ofs_q  <= '0;
    end else if (step) begin
      ofs_q  <= ofs_q + 1'b1;
    end
  end

  assign addr = {page_q, ofs_q};
endmodule

// File: rtl/nvpg_seq.sv
module nvpg_seq
  import nvpg_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1,
  parameter int ACC_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_port,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              wr_protect,
  output logic              ld_page,
  output logic              step,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int M1    = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int M2    = (HOLD_CYC > ACC_CYC) ? HOLD_CYC : ACC_CYC;
  localparam int MAXC  = (M1 > M2) ? M1 : M2;
  localparam int CNT_W = $clog2(MAXC) + 1;

  nvpg_state_e       st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] wdat_q;
  logic [DATA_W-1:0] rdat_q;
  logic              blk_q;
  logic              take;
  logic              cnt_done;

  assign req_ready = (st == ST_IDLE);
  assign take      = req_valid && req_ready;
  assign ld_page   = take && req_write && (req_port == PORT_PAGE);
  assign step      = take && !req_write && (req_port == PORT_XFER);
  assign cnt_done  = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      blk_q  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (take) begin
            if (req_write) begin
              if (req_port == PORT_XFER) begin
                wdat_q <= req_wdata;
                blk_q  <= wr_protect;
                cnt    <= CNT_W'(SETUP_CYC - 1);
                st     <= ST_WSET;
              end
            end else if (req_port == PORT_PAGE) begin
              cnt <= CNT_W'(ACC_CYC - 1);
              st  <= ST_RACC;
            end else begin
              rdat_q <= '0;
              st     <= ST_RSP;
            end
          end
        end
        ST_WSET: begin
          if (cnt_done) begin
            cnt <= CNT_W'(PULSE_CYC - 1);
            st  <= ST_WPUL;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WPUL: begin
          if (cnt_done) begin
            cnt <= CNT_W'(HOLD_CYC - 1);
            st  <= ST_WHLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WHLD: begin
          if (cnt_done) st <= ST_IDLE;
          else          cnt <= cnt - 1'b1;
        end
        ST_RACC: begin
          if (cnt_done) begin
            rdat_q <= mem_dq_in;
            st     <= ST_RSP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RSP: begin
          if (rsp_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_dq_oe = (st == ST_WSET) || (st == ST_WPUL) || (st == ST_WHLD);
    mem_ce_n  = !(mem_dq_oe || (st == ST_RACC));
    mem_oe_n  = (st != ST_RACC);
    mem_we_n  = !((st == ST_WPUL) && !blk_q);
  end

  assign mem_dq_out = wdat_q;
  assign rsp_valid  = (st == ST_RSP);
  assign rsp_data   = rdat_q;
endmodule

// File: rtl/nvpg_led.sv
module nvpg_led #(
  parameter int LED_HOLD = 8,
  localparam int LW      = $clog2(LED_HOLD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic led
);
  logic [LW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (trig)       cnt <= LW'(LED_HOLD);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign led = (cnt != '0);
endmodule

// File: rtl/nvram_page_ctrl.sv
module nvram_page_ctrl #(
  parameter int SECT_W    = 8,
  parameter int OFS_W     = 10,
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1,
  parameter int ACC_CYC   = 2,
  parameter int LED_HOLD  = 8,
  localparam int AW       = SECT_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_port,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              wr_protect,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              led_rd,
  output logic              led_wr
);
  logic       ld_page;
  logic       step;
  logic [1:0] act_trig;
  logic [1:0] act_led;

  nvpg_seq #(
    .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC), .ACC_CYC(ACC_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_port(req_port), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .wr_protect(wr_protect), .ld_page(ld_page), .step(step),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  nvpg_regs #(.SECT_W(SECT_W), .OFS_W(OFS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld_page(ld_page),
    .page_in(req_wdata[SECT_W-1:0]), .step(step), .addr(mem_addr)
  );

  assign act_trig = {!mem_we_n, !mem_oe_n};

  for (genvar g = 0; g < 2; g++) begin : g_led
    nvpg_led #(.LED_HOLD(LED_HOLD)) u_led (
      .clk(clk), .rst_n(rst_n), .trig(act_trig[g]), .led(act_led[g])
    );
  end

  assign led_rd = act_led[0];
  assign led_wr = act_led[1];
endmodule

// File: rtl/nvpg_checker.sv
module nvpg_checker #(
  parameter int SECT_W = 8,
  parameter int OFS_W  = 10,
  parameter int DATA_W = 8,
  localparam int AW    = SECT_W + OFS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              req_port,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              wr_protect,
  input logic [AW-1:0]     mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic              led_rd,
  input logic              led_wr
);
  logic              take;
  logic              page_wr;
  logic              adv_rd;
  logic              data_wr;
  logic              prot_win;
  logic [SECT_W-1:0] pg;
  logic [OFS_W-1:0]  of;

  assign take    = req_valid && req_ready;
  assign page_wr = take && req_write && !req_port;
  assign adv_rd  = take && !req_write && req_port;
  assign data_wr = take && req_write && req_port;
  assign pg      = mem_addr[AW-1:OFS_W];
  assign of      = mem_addr[OFS_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)       prot_win <= 1'b0;
    else if (data_wr) prot_win <= wr_protect;
    else if (req_ready) prot_win <= 1'b0;
  end

  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_dq_oe)); // R3
  AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_ce_n)); // R3
  AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_ce_n); // R3
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R2
  AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    page_wr |=> (of == '0) && (pg == $past(req_wdata[SECT_W-1:0]))); // R1
  AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv_rd |=> (of == OFS_W'($past(of) + 1'b1)) && $stable(pg)); // R4
  AST_ADV_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_rd && (&of)) |=> (of == '0) && $stable(pg)); // R5
  AST_PROTECT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    prot_win |-> mem_we_n); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R9
  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && mem_ce_n)); // R9
  AST_LED_WR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> led_wr); // R8
  AST_LED_RD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |=> led_rd); // R8
endmodule

bind nvram_page_ctrl nvpg_checker #(
  .SECT_W(SECT_W), .OFS_W(OFS_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_port(req_port), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .wr_protect(wr_protect), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe),
  .led_rd(led_rd), .led_wr(led_wr)
);

// File: tb/nvram_page_ctrl_bench.sv
module nvram_page_ctrl_bench;
  localparam int SECT_W = 3;
  localparam int OFS_W  = 4;
  localparam int DATA_W = 8;
  localparam int SETUP  = 2;
  localparam int PULSE  = 3;
  localparam int HOLD   = 1;
  localparam int ACC    = 2;
  localparam int LEDH   = 4;
  localparam int AW     = SECT_W + OFS_W;
  localparam int DEPTH  = 1 << AW;

  typedef struct {
    bit ce; bit oe; bit we; bit drv; bit prot; logic [7:0] d;
  } ent_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic req_port = 1'b0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic rsp_ready = 1'b1;
  logic wr_protect = 1'b0;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, led_rd, led_wr;
  logic [DATA_W-1:0] rsp_data, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;
  logic [7:0] dev [0:DEPTH-1];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit bp_mode = 1'b0;
  bit done = 1'b0;

  ent_t q[$];
  int m_page, m_ofs, rd_cnt, wr_cnt;
  bit rsp_pend;
  int rsp_exp;
  bit rsp_adv;
  int model [0:DEPTH-1];

  always #5 clk = ~clk;

  nvram_page_ctrl #(
    .SECT_W(SECT_W), .OFS_W(OFS_W), .DATA_W(DATA_W), .SETUP_CYC(SETUP),
    .PULSE_CYC(PULSE), .HOLD_CYC(HOLD), .ACC_CYC(ACC), .LED_HOLD(LEDH)
  ) u_nvram_page_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_port(req_port), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .wr_protect(wr_protect), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .led_rd(led_rd), .led_wr(led_wr)
  );

  // memory device
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? dev[mem_addr] : 8'h00;
  always @(posedge clk) if (!mem_ce_n && !mem_we_n) dev[mem_addr] <= mem_dq_out;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic ent_t mk(bit ce, bit oe, bit we, bit drv, bit prot, logic [7:0] d);
    ent_t e;
    e.ce = ce; e.oe = oe; e.we = we; e.drv = drv; e.prot = prot; e.d = d;
    return e;
  endfunction

  // cycle-by-cycle reference model, compared one ns after each falling edge
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      dev[i]   = 8'((i * 37 + 11) & 255);
      model[i] = (i * 37 + 11) & 255;
    end
    forever begin
      @(negedge clk);
      #1;
      cyc++;
      if (cyc > 60000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 60000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
      if (!rst_n) begin
        q.delete(); m_page = 0; m_ofs = 0; rd_cnt = 0; wr_cnt = 0;
        rsp_pend = 0; rsp_exp = 0; rsp_adv = 0;
      end else begin
        ent_t e;
        bit has;
        bit exp_rdy;
        int exp_addr;
        has = (q.size() > 0);
        e = has ? q.pop_front() : mk(1, 1, 1, 0, 0, 8'h00);
        exp_rdy = !has && !rsp_pend;
        exp_addr = m_page * (1 << OFS_W) + m_ofs;
        chk(mem_ce_n == e.ce, "R2 ce", int'(mem_ce_n), int'(e.ce));
        chk(mem_oe_n == e.oe, "R2 oe", int'(mem_oe_n), int'(e.oe));
        chk(mem_we_n == e.we, e.prot ? "R7 we" : "R3 we", int'(mem_we_n), int'(e.we));
        chk(mem_dq_oe == e.drv, "R3 dq_oe", int'(mem_dq_oe), int'(e.drv));
        if (e.drv) chk(mem_dq_out == e.d, "R3 dq_out", int'(mem_dq_out), int'(e.d));
        chk(int'(mem_addr) == exp_addr, "R6 addr", int'(mem_addr), exp_addr);
        chk(req_ready == exp_rdy, "R9 req_ready", int'(req_ready), int'(exp_rdy));
        chk(rsp_valid == (!has && rsp_pend), "R9 rsp_valid", int'(rsp_valid), int'(!has && rsp_pend));
        if (!has && rsp_pend)
          chk(int'(rsp_data) == rsp_exp, rsp_adv ? "R4 rsp_data" : "R2 rsp_data",
              int'(rsp_data), rsp_exp);
        chk(led_rd == (rd_cnt != 0), "R8 led_rd", int'(led_rd), int'(rd_cnt != 0));
        chk(led_wr == (wr_cnt != 0), "R8 led_wr", int'(led_wr), int'(wr_cnt != 0));
        rd_cnt = !e.oe ? LEDH : (rd_cnt > 0 ? rd_cnt - 1 : 0);
        wr_cnt = !e.we ? LEDH : (wr_cnt > 0 ? wr_cnt - 1 : 0);
        if (!has && rsp_pend && rsp_ready) rsp_pend = 0;
        if (exp_rdy && req_valid) begin
          if (req_write && !req_port) begin
            m_page = int'(req_wdata) & ((1 << SECT_W) - 1);
            m_ofs = 0;
          end else if (!req_write && req_port) begin
            m_ofs = (m_ofs + 1) % (1 << OFS_W);
            rsp_pend = 1; rsp_exp = 0; rsp_adv = 1;
          end else if (!req_write) begin
            for (int k = 0; k < ACC; k++) q.push_back(mk(0, 0, 1, 0, 0, 8'h00));
            rsp_pend = 1; rsp_exp = model[exp_addr]; rsp_adv = 0;
          end else begin
            for (int k = 0; k < SETUP; k++) q.push_back(mk(0, 1, 1, 1, wr_protect, req_wdata));
            for (int k = 0; k < PULSE; k++) q.push_back(mk(0, 1, wr_protect, 1, wr_protect, req_wdata));
            for (int k = 0; k < HOLD; k++) q.push_back(mk(0, 1, 1, 1, wr_protect, req_wdata));
            if (!wr_protect) model[exp_addr] = int'(req_wdata);
          end
        end
      end
    end
  end

  // response back-pressure pattern
  initial begin
    forever begin
      @(negedge clk);
      rsp_ready = bp_mode ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  task automatic issue(input bit w, input bit p, input logic [7:0] d, input bit prot);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_port = p; req_wdata = d; wr_protect = prot;
    #2;
    while (!req_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    wr_protect = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    #2;
    while (!req_ready) begin
      @(negedge clk);
      #2;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #2;
    // R10: reset state
    chk(mem_addr == '0 && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe,
        "R10 reset strobes/addr", int'(mem_addr), 0);
    chk(req_ready && !rsp_valid && !led_rd && !led_wr, "R10 reset handshake/leds",
        int'({req_ready, rsp_valid, led_rd, led_wr}), 8);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: page select clears offset
    issue(1, 0, 8'h05, 0);
    issue(0, 1, 8'h00, 0);
    issue(0, 1, 8'h00, 0);
    issue(1, 0, 8'h05, 0);
    settle();
    chk(mem_addr == AW'(5 << OFS_W), "R1 page load clears offset", int'(mem_addr), 5 << OFS_W);

    // R3 write, R4 advance, R2 read back
    issue(1, 1, 8'hA5, 0);
    issue(0, 1, 8'h00, 0);
    issue(1, 1, 8'h3C, 0);
    issue(1, 0, 8'h05, 0);
    issue(0, 0, 8'h00, 0);
    issue(0, 1, 8'h00, 0);
    issue(0, 0, 8'h00, 0);
    settle();
    chk(dev[AW'(5 << OFS_W)] == 8'hA5, "R3 stored byte", int'(dev[AW'(5 << OFS_W)]), 8'hA5);

    // R7: protected write leaves memory untouched
    issue(1, 1, 8'hFF, 1);
    issue(0, 0, 8'h00, 0);
    settle();
    chk(dev[AW'((5 << OFS_W) + 1)] == 8'h3C, "R7 protected byte kept",
        int'(dev[AW'((5 << OFS_W) + 1)]), 8'h3C);

    // R5: offset wrap keeps page; upper page bits beyond SECT_W dropped (R1)
    issue(1, 0, 8'hFA, 0);
    for (int k = 0; k < (1 << OFS_W); k++) issue(0, 1, 8'h00, 0);
    settle();
    chk(mem_addr == AW'(2 << OFS_W), "R5 wrap to offset 0 same page", int'(mem_addr), 2 << OFS_W);
    issue(1, 1, 8'h77, 0);
    issue(0, 0, 8'h00, 0);

    // R9: response back-pressure with mixed traffic
    bp_mode = 1'b1;
    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 15)      issue(1, 0, 8'($urandom), 0);
      else if (r < 45) issue(0, 0, 8'h00, 0);
      else if (r < 70) issue(1, 1, 8'($urandom), (($urandom % 5) == 0));
      else             issue(0, 1, 8'h00, 0);
    end
    bp_mode = 1'b0;
    settle();
    repeat (LEDH + 2) @(negedge clk);
    #2;
    chk(!led_rd && !led_wr, "R8 leds drop after hold", int'({led_rd, led_wr}), 0);
    for (int i = 0; i < DEPTH; i++)
      if (int'(dev[i]) != model[i]) chk(0, "R3 memory image", int'(dev[i]), model[i]);
    checks++;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule